// File: doc/BRIEF.md
# Bus-to-Memory Width Adapting Access Sequencer

This block sits between a simple single-transfer request port and an external asynchronous memory with a 16-bit data bus. Each request carries an address, a size (byte, halfword or word), a write flag and write data. The block turns it into one or two timed memory cycles and drives chip select, halfword address, active-low byte-lane enables, output enable and write enable. Read data is placed back into the proper bus byte positions before the request port becomes ready again.

The top four address bits must match a configured region. Inside that region the next two bits pick one of four active-low chip selects. A word transfer becomes two halfword cycles at consecutive memory addresses, lower half first. The chip select stays low through both cycles and the idle clock between them. Each chip select has a configuration bit that says whether its device honours byte lanes. A byte write to a lane-aware device enables only the addressed lane. A byte write to any other device enables both lanes.

Top module: `mem_width_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress: req_ready is 1, every mem_cs_n bit is 1, mem_oe_n and mem_we_n are 1, mem_be_n is 2'b11, mem_dq_oe is 0 and rsp_valid is 0.
- R2: A halfword transfer (req_size 2'd1) performs exactly one memory cycle at mem_addr = req_addr[25:1], with mem_be_n = 2'b00.
- R3: A word transfer (req_size 2'd2) performs two memory cycles: the first at req_addr[25:1] carrying bus bits 15:0, then one idle clock with both strobes high, then the second at that address plus one carrying bus bits 31:16.
- R4: Exactly one chip select is low during a transfer. For a word transfer it stays low and unchanged from the first strobe clock through the idle clock to the last strobe clock.
- R5: A byte write (req_size 2'd0) to a chip select whose bytesel_cfg bit is 1 drives mem_be_n = 2'b10 when req_addr[0] is 0 and 2'b01 when it is 1. The addressed bus byte, taken from req_wdata bits 8*req_addr[1:0]+7 down to 8*req_addr[1:0], appears on both halves of mem_dq_out.
- R6: Every read cycle drives mem_be_n = 2'b00. A byte read returns the lane selected by req_addr[0] in bus byte req_addr[1:0], with all other rsp_rdata bits 0.
- R7: A byte write to a chip select whose bytesel_cfg bit is 0 is done as a full 16-bit write with mem_be_n = 2'b00.
- R8: The chip select index is req_addr[27:26]. Chip select i drives mem_cs_n bit i low. A transfer is in the region only when req_addr[31:28] equals REGION_BASE (default 4'h6).
- R9: A request outside the region asserts no chip select and no strobe. In the clock after acceptance it gives rsp_valid = 1 with rsp_err = 1, and req_ready stays 1.
- R10: req_ready is 0 from the clock after acceptance until completion. At completion rsp_valid pulses for one clock with req_ready = 1 and rsp_err = 0. For a read, rsp_rdata holds a halfword in bits 31:16 if req_addr[1] is 1 and in bits 15:0 otherwise, or a word as {second cycle, first cycle}, with unused bits 0.
- R11: Each memory cycle holds its strobe low for exactly CYC_CLKS clocks (default 3): mem_oe_n for a read, mem_we_n for a write, never both. Read data is sampled at the end of the last strobe clock, and mem_dq_oe is 1 throughout a write transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data in bus byte positions |
| bytesel_cfg | input | NUM_CS | Per chip select: device honours byte lanes |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completion was an out-of-region error |
| rsp_rdata | output | 32 | Assembled read data |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_addr | output | MEM_AW | Halfword address inside the subregion |
| mem_be_n | output | 2 | Active-low byte-lane enables, bit 0 lower lane |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 16 | Write data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Read data from memory |

## Verification
On every clock the assertions check that at most one chip select is active and that both strobes are never low together. They also check that the chip select does not move while the block is busy, that strobes stay high while it is idle, and that error completions never select a device. Address sequencing, the lane-enable choice between lane-aware and other devices, the exact strobe length and the placement of returned bytes can only be shown by the bench scenarios. There, a behavioural model predicts every pin on every clock and the read data from a known memory pattern.

// File: rtl/mws_pkg.sv
package mws_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_GAP    = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [1:0]  be_n;
    logic [15:0] wdata;
  } lane_drive_t;
endpackage

// File: rtl/mws_addr_decode.sv
module mws_addr_decode #(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 4,
  parameter logic [REGION_BITS-1:0] REGION_BASE = 4'h6,
  parameter int NUM_CS      = 4,
  parameter int CS_IDX_W    = $clog2(NUM_CS),
  parameter int MEM_AW      = ADDR_W - REGION_BITS - CS_IDX_W - 1
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [CS_IDX_W-1:0] cs_idx,
  output logic [MEM_AW-1:0]   mem_addr
);
  localparam int SUB_LSB = ADDR_W - REGION_BITS - CS_IDX_W;

  always_comb begin
    hit      = (addr[ADDR_W-1 -: REGION_BITS] == REGION_BASE);
    cs_idx   = addr[SUB_LSB +: CS_IDX_W];
    mem_addr = addr[SUB_LSB-1:1];
  end
endmodule

// File: rtl/mws_lane_map.sv
module mws_lane_map
  import mws_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  addr_lo,
  input  logic        write,
  input  logic        bytesel,
  input  logic        upper_sub,
  input  logic [31:0] wdata,
  output lane_drive_t drive
);
  logic [7:0] sel_byte;

  always_comb begin
    sel_byte    = wdata[{addr_lo, 3'b000} +: 8];
    drive.be_n  = 2'b00;
    drive.wdata = 16'h0000;
    if (write) begin
      case (size)
        SZ_BYTE: begin
          drive.wdata = {sel_byte, sel_byte};
          if (bytesel) drive.be_n = addr_lo[0] ? 2'b01 : 2'b10;
        end
        SZ_HALF: drive.wdata = addr_lo[1] ? wdata[31:16] : wdata[15:0];
        default: drive.wdata = upper_sub ? wdata[31:16] : wdata[15:0];
      endcase
    end
  end
endmodule

// File: rtl/mws_rd_assemble.sv
module mws_rd_assemble
  import mws_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        capture,
  input  logic [1:0]  size,
  input  logic [1:0]  addr_lo,
  input  logic        upper_sub,
  input  logic [15:0] dq_in,
  output logic [31:0] rdata
);
  logic [31:0] rdata_q;
  logic [31:0] rdata_d;
  logic [7:0]  lane_byte;

  always_comb begin
    lane_byte = addr_lo[0] ? dq_in[15:8] : dq_in[7:0];
    rdata_d   = 32'h0;
    case (size)
      SZ_BYTE: rdata_d[{addr_lo, 3'b000} +: 8] = lane_byte;
      SZ_HALF: rdata_d = addr_lo[1] ? {dq_in, 16'h0} : {16'h0, dq_in};
      default: rdata_d = upper_sub ? {dq_in, rdata_q[15:0]} : {16'h0, dq_in};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= 32'h0;
    else if (capture) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/mem_width_seq.sv
module mem_width_seq
  import mws_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 4,
  parameter logic [REGION_BITS-1:0] REGION_BASE = 4'h6,
  parameter int NUM_CS      = 4,
  parameter int CYC_CLKS    = 3,
  parameter int MEM_AW      = ADDR_W - REGION_BITS - $clog2(NUM_CS) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic [NUM_CS-1:0] bytesel_cfg,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_be_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int CS_IDX_W = $clog2(NUM_CS);
  localparam int CNT_W    = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_CLKS - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              upper_q;
  logic [1:0]        size_q;
  logic [1:0]        addr_lo_q;
  logic              write_q;
  logic [31:0]       wdata_q;
  logic              bytesel_q;

  logic [NUM_CS-1:0] cs_n_q;
  logic [MEM_AW-1:0] maddr_q;
  logic [1:0]        be_n_q;
  logic              oe_n_q;
  logic              we_n_q;
  logic [15:0]       dq_q;
  logic              dq_oe_q;
  logic              ready_q;
  logic              rsp_valid_q;
  logic              rsp_err_q;

  logic              dec_hit;
  logic [CS_IDX_W-1:0] dec_idx;
  logic [MEM_AW-1:0] dec_maddr;

  logic              idle;
  logic [1:0]        lm_size;
  logic [1:0]        lm_addr_lo;
  logic              lm_write;
  logic              lm_bytesel;
  logic [31:0]       lm_wdata;
  lane_drive_t       lm_drive;

  logic              strobe_last;
  logic              need_upper;
  logic              rd_capture;

  mws_addr_decode #(
    .ADDR_W      (ADDR_W),
    .REGION_BITS (REGION_BITS),
    .REGION_BASE (REGION_BASE),
    .NUM_CS      (NUM_CS),
    .CS_IDX_W    (CS_IDX_W),
    .MEM_AW      (MEM_AW)
  ) u_decode (
    .addr     (req_addr),
    .hit      (dec_hit),
    .cs_idx   (dec_idx),
    .mem_addr (dec_maddr)
  );

  always_comb begin
    idle       = (state_q == ST_IDLE);
    lm_size    = idle ? req_size    : size_q;
    lm_addr_lo = idle ? req_addr[1:0] : addr_lo_q;
    lm_write   = idle ? req_write   : write_q;
    lm_wdata   = idle ? req_wdata   : wdata_q;
    lm_bytesel = idle ? bytesel_cfg[dec_idx] : bytesel_q;
    strobe_last = (state_q == ST_STROBE) && (cnt_q == CNT_LAST);
    need_upper  = size_q[1] && !upper_q;
    rd_capture  = strobe_last && !write_q;
  end

  mws_lane_map u_lane (
    .size      (lm_size),
    .addr_lo   (lm_addr_lo),
    .write     (lm_write),
    .bytesel   (lm_bytesel),
    .upper_sub (!idle),
    .wdata     (lm_wdata),
    .drive     (lm_drive)
  );

  mws_rd_assemble u_rd (
    .clk       (clk),
    .rst       (rst),
    .capture   (rd_capture),
    .size      (size_q),
    .addr_lo   (addr_lo_q),
    .upper_sub (upper_q),
    .dq_in     (mem_dq_in),
    .rdata     (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      upper_q     <= 1'b0;
      size_q      <= 2'd0;
      addr_lo_q   <= 2'd0;
      write_q     <= 1'b0;
      wdata_q     <= 32'h0;
      bytesel_q   <= 1'b0;
      cs_n_q      <= '1;
      maddr_q     <= '0;
      be_n_q      <= 2'b11;
      oe_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      dq_q        <= 16'h0;
      dq_oe_q     <= 1'b0;
      ready_q     <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (!dec_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= 1'b1;
            end else begin
              state_q   <= ST_STROBE;
              cnt_q     <= '0;
              upper_q   <= 1'b0;
              size_q    <= req_size;
              addr_lo_q <= req_addr[1:0];
              write_q   <= req_write;
              wdata_q   <= req_wdata;
              bytesel_q <= bytesel_cfg[dec_idx];
              cs_n_q    <= ~(NUM_CS'(1) << dec_idx);
              maddr_q   <= dec_maddr;
              be_n_q    <= lm_drive.be_n;
              dq_q      <= lm_drive.wdata;
              dq_oe_q   <= req_write;
              oe_n_q    <= req_write;
              we_n_q    <= !req_write;
              ready_q   <= 1'b0;
            end
          end
        end
        ST_STROBE: begin
          if (strobe_last) begin
            oe_n_q <= 1'b1;
            we_n_q <= 1'b1;
            if (need_upper) begin
              state_q <= ST_GAP;
              upper_q <= 1'b1;
              maddr_q <= maddr_q + MEM_AW'(1);
              be_n_q  <= lm_drive.be_n;
              dq_q    <= lm_drive.wdata;
            end else begin
              state_q     <= ST_IDLE;
              cs_n_q      <= '1;
              be_n_q      <= 2'b11;
              dq_oe_q     <= 1'b0;
              ready_q     <= 1'b1;
              rsp_valid_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_GAP: begin
          state_q <= ST_STROBE;
          cnt_q   <= '0;
          oe_n_q  <= write_q;
          we_n_q  <= !write_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = ready_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_err    = rsp_err_q;
  assign mem_cs_n   = cs_n_q;
  assign mem_addr   = maddr_q;
  assign mem_be_n   = be_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_dq_out = dq_q;
  assign mem_dq_oe  = dq_oe_q;
endmodule

// File: rtl/mws_checker.sv
module mws_checker #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);
  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_oe_n || mem_we_n);

  // R4
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_cs_n));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_oe_n && mem_we_n));

  // R9
  err_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (mem_cs_n == {NUM_CS{1'b1}}));

  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
endmodule

bind mem_width_seq mws_checker #(.NUM_CS(NUM_CS)) u_mws_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/mem_width_seq_bench.sv
module mem_width_seq_bench;
  localparam int CYC = 3;
  localparam int AW  = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  bytesel_cfg = 4'b1011;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_cs_n;
  logic [AW-1:0] mem_addr;
  logic [1:0]  mem_be_n;
  logic        mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hC35A;
  endfunction

  assign mem_dq_in = (&mem_cs_n) ? 16'h0000 : pat(mem_addr);

  mem_width_seq u_mem_width_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .bytesel_cfg(bytesel_cfg), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "ready", 32'(req_ready), 32'd1);
    chk(tag, "cs_n", 32'(mem_cs_n), 32'hF);
    chk(tag, "oe_n", 32'(mem_oe_n), 32'd1);
    chk(tag, "we_n", 32'(mem_we_n), 32'd1);
    chk(tag, "be_n", 32'(mem_be_n), 32'd3);
    chk(tag, "dq_oe", 32'(mem_dq_oe), 32'd0);
  endtask

  // Predicts every busy clock of an in-region transfer, then the completion.
  task automatic xfer(input logic [31:0] a, input logic [1:0] sz,
                      input logic wr, input logic [31:0] wd);
    logic [3:0]    e_cs;
    logic [AW-1:0] e_ma;
    logic [1:0]    e_be;
    logic [15:0]   e_dq;
    logic [7:0]    b;
    logic [15:0]   h;
    logic [31:0]   e_rd;
    int            nsub;
    e_cs = ~(4'b0001 << a[27:26]);
    e_ma = a[25:1];
    nsub = (sz == 2'd2) ? 2 : 1;
    @(negedge clk);
    chk("R1", "ready before accept", 32'(req_ready), 32'd1);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int s = 0; s < nsub; s++) begin
      e_be = 2'b00;
      b = wd[{a[1:0], 3'b000} +: 8];
      if (sz == 2'd0) begin
        e_dq = {b, b};
        if (wr && bytesel_cfg[a[27:26]]) e_be = a[0] ? 2'b01 : 2'b10;
      end else if (sz == 2'd1) e_dq = a[1] ? wd[31:16] : wd[15:0];
      else e_dq = (s == 1) ? wd[31:16] : wd[15:0];
      for (int k = 0; k < CYC; k++) begin
        chk("R4", "cs_n", 32'(mem_cs_n), 32'(e_cs));
        chk("R3", "addr", 32'(mem_addr), 32'(e_ma + AW'(s)));
        chk(wr ? (sz == 2'd0 ? (bytesel_cfg[a[27:26]] ? "R5" : "R7") : "R2") : "R6",
            "be_n", 32'(mem_be_n), 32'(e_be));
        chk("R11", "oe_n", 32'(mem_oe_n), 32'(wr));
        chk("R11", "we_n", 32'(mem_we_n), 32'(!wr));
        chk("R10", "ready busy", 32'(req_ready), 32'd0);
        chk("R11", "dq_oe", 32'(mem_dq_oe), 32'(wr));
        if (wr) chk("R5", "dq_out", 32'(mem_dq_out), 32'(e_dq));
        @(negedge clk);
      end
      if (s == 0 && nsub == 2) begin
        chk("R4", "cs_n gap", 32'(mem_cs_n), 32'(e_cs));
        chk("R3", "gap strobes", {mem_oe_n, mem_we_n}, 32'd3);
        chk("R3", "gap addr", 32'(mem_addr), 32'(e_ma + AW'(1)));
        chk("R10", "ready gap", 32'(req_ready), 32'd0);
        @(negedge clk);
      end
    end
    chk("R10", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R10", "rsp_err", 32'(rsp_err), 32'd0);
    chk_idle("R1");
    if (!wr) begin
      h = pat(e_ma);
      if (sz == 2'd0) begin
        b = a[0] ? h[15:8] : h[7:0];
        e_rd = 32'(b) << (8 * a[1:0]);
      end else if (sz == 2'd1) e_rd = a[1] ? {h, 16'h0} : {16'h0, h};
      else e_rd = {pat(e_ma + AW'(1)), h};
      chk(sz == 2'd0 ? "R6" : "R10", "rdata", rsp_rdata, e_rd);
    end
    @(negedge clk);
    chk("R10", "rsp pulse ends", 32'(rsp_valid), 32'd0);
  endtask

  task automatic bad_xfer(input logic [31:0] a);
    @(negedge clk);
    req_addr = a; req_size = 2'd1; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R9", "rsp_err", 32'(rsp_err), 32'd1);
    chk_idle("R9");
    @(negedge clk);
    chk("R9", "rsp pulse ends", 32'(rsp_valid), 32'd0);
    chk("R9", "cs_n after", 32'(mem_cs_n), 32'hF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    chk("R1", "rsp_valid reset", 32'(rsp_valid), 32'd0);
    xfer(32'h6000_0010, 2'd1, 1'b0, 32'h0);            // R2 lower halfword read
    xfer(32'h6400_0122, 2'd1, 1'b0, 32'h0);            // R10 upper halfword, R8 cs1
    xfer(32'h6800_0200, 2'd2, 1'b0, 32'h0);            // R3 word read, cs2
    xfer(32'h6C00_0300, 2'd2, 1'b1, 32'hDEAD_BEEF);    // R3 word write, cs3
    xfer(32'h6000_0041, 2'd0, 1'b1, 32'h1122_3344);    // R5 upper lane
    xfer(32'h6000_0042, 2'd0, 1'b1, 32'h1122_3344);    // R5 lower lane
    xfer(32'h6800_0043, 2'd0, 1'b1, 32'hA1B2_C3D4);    // R7 cs2 without byte lanes
    xfer(32'h6400_0053, 2'd0, 1'b0, 32'h0);            // R6 byte read upper lane
    xfer(32'h6800_0050, 2'd0, 1'b0, 32'h0);            // R6 byte read, no byte lanes
    xfer(32'h6000_0062, 2'd1, 1'b1, 32'h5A5A_0F0F);    // R2 halfword write
    bad_xfer(32'h7000_0000);                           // R9
    bad_xfer(32'h0000_0004);                           // R9
    xfer(32'h6FFF_FFFC, 2'd2, 1'b0, 32'h0);            // R8 top of cs3, R3
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule